// File: doc/BRIEF.md
# Control-Register Access Permission Checker

This block decides, in the same cycle, whether an instruction may touch a control and status register. It looks at the 12-bit register address, the hart's current privilege, whether the access writes, the virtual-memory trap bit and two three-bit counter-enable masks. It produces one signal, `access_ok`. When this signal is low, the pipeline raises an illegal-instruction exception. The decision itself is purely combinational. Reading and writing the register data, and any side effects, belong to other logic.

Four checks are ANDed to form the result. The first is a table of implemented addresses, each with the privileges that may use it. The second covers the permission fields encoded inside the address itself. The third traps the address-translation register for the supervisor. The fourth is a counter gate. The gate exposes the cycle, time and retired-instruction counters to lower privileges only when the level above allows it, and it always refuses the unimplemented performance-counter slots that follow those three.

The block also holds the two counter-enable registers, one owned by machine mode and one by supervisor mode. Each register keeps only its low three bits. Their writes arrive on dedicated strobes, and their current values are visible on output ports.

Top module: `csr_perm_gate`

## Requirements
- R1: When `is_write` is 1 and address bits [11:10] are 2'b11, `access_ok` is 0.
- R2: The privilege is encoded as user=2'b00, supervisor=2'b01, machine=2'b11. When this value is below address bits [9:8] (unsigned), `access_ok` is 0.
- R3: When `vm_trap` is 1, an access to address 0x180 from supervisor mode gives `access_ok` 0. Without the trap bit, or from machine mode, the same access is allowed.
- R4: From supervisor mode, addresses 0xC00, 0xC01 and 0xC02 are legal only when machine counter-enable bit 0, 1 or 2 respectively is set.
- R5: From user mode, addresses 0xC00, 0xC01 and 0xC02 are legal only when supervisor counter-enable bit 0, 1 or 2 respectively is set.
- R6: Addresses 0xC03 through 0xC1F always give `access_ok` 0.
- R7: Addresses 0xF11–0xF14, 0x300–0x306, 0x340–0x344, 0x3A0 and 0x7A0 are defined for machine mode only.
- R8: Addresses 0x100, 0x102–0x106, 0x140–0x144 and 0x180 are defined for supervisor and machine mode. Every address not listed in R7, R8 or R11 is undefined, and this includes 0x3B0. An undefined address gives `access_ok` 0.
- R9: Both counter-enable registers reset to 0. A write stores bits [2:0] of the write data, and every other bit reads 0.
- R10: The reserved privilege code 2'b10 makes every access illegal.
- R11: Addresses 0xC00–0xC02 are defined for user, supervisor and machine mode. In machine mode they are not gated by either enable register.
- R12: For any other input, `access_ok` is 1 exactly when the address is defined for the privilege and passes R1, R2, R3 and the counter gate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the counter-enable registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_addr | input | 12 | Register address of the access |
| priv | input | 2 | Current privilege (00 user, 01 supervisor, 11 machine) |
| is_write | input | 1 | The access writes the register |
| vm_trap | input | 1 | Trap supervisor accesses to the translation register |
| menab_we | input | 1 | Write strobe, machine counter-enable register |
| menab_wdata | input | 64 | Write data, machine counter-enable register |
| senab_we | input | 1 | Write strobe, supervisor counter-enable register |
| senab_wdata | input | 64 | Write data, supervisor counter-enable register |
| menab_q | output | 32 | Machine counter-enable register value |
| senab_q | output | 32 | Supervisor counter-enable register value |
| access_ok | output | 1 | Access is legal |

## Verification
The concurrent assertions assume that the address, privilege and write-flag inputs are steady at each rising clock edge. The bench respects this by changing them only at whole nanoseconds, which never coincide with an edge. The enable-register assertions assume that write strobes last a whole cycle, so the bench drives them from one falling edge to the next. The privilege-floor assertion holds for the reserved code as well, which lets the sweeps include the value 2'b10 on purpose. Enable values are changed only between sweeps, never during one.

// File: rtl/csr_perm_pkg.sv
package csr_perm_pkg;

   typedef enum logic [1:0] {
      PRV_USER  = 2'b00,
      PRV_SUPER = 2'b01,
      PRV_RSVD  = 2'b10,
      PRV_MACH  = 2'b11
   } prv_e;

   // Which privileges a span of defined addresses admits
   typedef enum logic [1:0] {
      SPAN_MACH_ONLY = 2'd0,
      SPAN_SUP_UP    = 2'd1,
      SPAN_ANY       = 2'd2
   } span_cls_e;

   localparam int CSR_ADDR_W   = 12;
   localparam int NUM_SPANS    = 10;

   // Span table: lower bound, upper bound, class
   localparam logic [11:0] SPAN_LO [NUM_SPANS] = '{
      12'hF11, 12'h300, 12'h340, 12'h3A0, 12'h7A0,
      12'h100, 12'h102, 12'h140, 12'h180, 12'hC00 };
   localparam logic [11:0] SPAN_HI [NUM_SPANS] = '{
      12'hF14, 12'h306, 12'h344, 12'h3A0, 12'h7A0,
      12'h100, 12'h106, 12'h144, 12'h180, 12'hC02 };
   localparam span_cls_e SPAN_CLS [NUM_SPANS] = '{
      SPAN_MACH_ONLY, SPAN_MACH_ONLY, SPAN_MACH_ONLY, SPAN_MACH_ONLY, SPAN_MACH_ONLY,
      SPAN_SUP_UP, SPAN_SUP_UP, SPAN_SUP_UP, SPAN_SUP_UP, SPAN_ANY };

   function automatic logic span_admits(span_cls_e cls, logic [1:0] p);
      logic ok;
      case (cls)
         SPAN_MACH_ONLY: ok = (p == PRV_MACH);
         SPAN_SUP_UP:    ok = (p == PRV_MACH) || (p == PRV_SUPER);
         SPAN_ANY:       ok = (p == PRV_MACH) || (p == PRV_SUPER) || (p == PRV_USER);
         default:        ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/csr_defined_table.sv
module csr_defined_table
   import csr_perm_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        priv,
   output logic              defined
);

   if (ADDR_W != CSR_ADDR_W) begin : g_bad_width
      $error("csr_defined_table: ADDR_W must be %0d", CSR_ADDR_W);
   end

   logic [NUM_SPANS-1:0] hit;

   for (genvar s = 0; s < NUM_SPANS; s++) begin : g_span
      localparam logic [ADDR_W-1:0] LO = SPAN_LO[s];
      localparam logic [ADDR_W-1:0] HI = SPAN_HI[s];
      localparam span_cls_e         CL = SPAN_CLS[s];
      logic in_rng;
      if (LO == HI) begin : g_single
         assign in_rng = (addr == LO);
      end else begin : g_range
         assign in_rng = (addr >= LO) && (addr <= HI);
      end
      assign hit[s] = in_rng && span_admits(CL, priv);
   end

   assign defined = |hit;

endmodule

// File: rtl/csr_field_check.sv
module csr_field_check #(
   parameter int          ADDR_W  = 12,
   parameter int          RO_MSB  = 11,
   parameter int          PRV_MSB = 9,
   parameter logic [1:0]  RO_CODE = 2'b11
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        priv,
   input  logic              is_write,
   output logic              field_ok
);

   localparam int RO_LSB  = RO_MSB - 1;
   localparam int PRV_LSB = PRV_MSB - 1;

   if (RO_MSB >= ADDR_W || PRV_MSB >= ADDR_W || RO_LSB <= PRV_MSB) begin : g_bad_fields
      $error("csr_field_check: field positions overlap or exceed the address");
   end

   logic ro_hit;
   logic floor_ok;

   assign ro_hit   = is_write && (addr[RO_MSB:RO_LSB] == RO_CODE);
   assign floor_ok = (priv >= addr[PRV_MSB:PRV_LSB]);
   assign field_ok = !ro_hit && floor_ok;

endmodule

// File: rtl/csr_counter_gate.sv
module csr_counter_gate
   import csr_perm_pkg::*;
#(
   parameter int              ADDR_W    = 12,
   parameter int              ENAB_W    = 32,
   parameter int              WDATA_W   = 64,
   parameter int              NUM_GATED = 3,
   parameter int              HPM_SLOTS = 32,
   parameter logic [11:0]     CNT_BASE  = 12'hC00
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               m_we,
   input  logic [WDATA_W-1:0] m_wdata,
   input  logic               s_we,
   input  logic [WDATA_W-1:0] s_wdata,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [1:0]         priv,
   output logic [ENAB_W-1:0]  menab_q,
   output logic [ENAB_W-1:0]  senab_q,
   output logic               gate_ok
);

   localparam int HPM_LAST = int'(CNT_BASE) + HPM_SLOTS - 1;

   if (NUM_GATED < 1 || NUM_GATED > ENAB_W || NUM_GATED > WDATA_W || NUM_GATED > HPM_SLOTS) begin : g_bad_cnt
      $error("csr_counter_gate: NUM_GATED out of range");
   end

   // Enable registers: only the gated positions are stored
   for (genvar b = 0; b < ENAB_W; b++) begin : g_bit
      if (b < NUM_GATED) begin : g_store
         logic m_bit, s_bit;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               m_bit <= 1'b0;
               s_bit <= 1'b0;
            end else begin
               if (m_we) m_bit <= m_wdata[b];
               if (s_we) s_bit <= s_wdata[b];
            end
         end
         assign menab_q[b] = m_bit;
         assign senab_q[b] = s_bit;
      end else begin : g_zero
         assign menab_q[b] = 1'b0;
         assign senab_q[b] = 1'b0;
      end
   end

   // Per-counter visibility
   logic [NUM_GATED-1:0] sel;
   logic [NUM_GATED-1:0] deny;
   for (genvar c = 0; c < NUM_GATED; c++) begin : g_cnt
      localparam logic [ADDR_W-1:0] CADDR = ADDR_W'(int'(CNT_BASE) + c);
      assign sel[c]  = (addr == CADDR);
      assign deny[c] = sel[c] &&
                       (((priv == PRV_SUPER) && !menab_q[c]) ||
                        ((priv == PRV_USER)  && !senab_q[c]));
   end

   logic hpm_slot;
   assign hpm_slot = (int'(addr) >= int'(CNT_BASE) + NUM_GATED) && (int'(addr) <= HPM_LAST);
   assign gate_ok  = !hpm_slot && !(|deny);

   // Assertions
   p_enab_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (menab_q[ENAB_W-1:NUM_GATED] == '0) && (senab_q[ENAB_W-1:NUM_GATED] == '0));

   p_menab_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      m_we |=> (menab_q[NUM_GATED-1:0] == $past(m_wdata[NUM_GATED-1:0])));

   p_senab_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      s_we |=> (senab_q[NUM_GATED-1:0] == $past(s_wdata[NUM_GATED-1:0])));

   p_menab_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !m_we |=> $stable(menab_q));

   p_hpm_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      hpm_slot |-> !gate_ok);

endmodule

// File: rtl/csr_perm_gate.sv
module csr_perm_gate
   import csr_perm_pkg::*;
#(
   parameter int          ADDR_W    = 12,
   parameter int          ENAB_W    = 32,
   parameter int          WDATA_W   = 64,
   parameter int          NUM_GATED = 3,
   parameter int          HPM_SLOTS = 32,
   parameter logic [11:0] SATP_ADDR = 12'h180,
   parameter logic [11:0] CNT_BASE  = 12'hC00
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  csr_addr,
   input  logic [1:0]         priv,
   input  logic               is_write,
   input  logic               vm_trap,
   input  logic               menab_we,
   input  logic [WDATA_W-1:0] menab_wdata,
   input  logic               senab_we,
   input  logic [WDATA_W-1:0] senab_wdata,
   output logic [ENAB_W-1:0]  menab_q,
   output logic [ENAB_W-1:0]  senab_q,
   output logic               access_ok
);

   logic defined;
   logic field_ok;
   logic gate_ok;
   logic vm_ok;

   csr_defined_table #(.ADDR_W(ADDR_W)) u_table (
      .addr    (csr_addr),
      .priv    (priv),
      .defined (defined)
   );

   csr_field_check #(.ADDR_W(ADDR_W)) u_fields (
      .addr     (csr_addr),
      .priv     (priv),
      .is_write (is_write),
      .field_ok (field_ok)
   );

   csr_counter_gate #(
      .ADDR_W    (ADDR_W),
      .ENAB_W    (ENAB_W),
      .WDATA_W   (WDATA_W),
      .NUM_GATED (NUM_GATED),
      .HPM_SLOTS (HPM_SLOTS),
      .CNT_BASE  (CNT_BASE)
   ) u_counters (
      .clk     (clk),
      .rst_n   (rst_n),
      .m_we    (menab_we),
      .m_wdata (menab_wdata),
      .s_we    (senab_we),
      .s_wdata (senab_wdata),
      .addr    (csr_addr),
      .priv    (priv),
      .menab_q (menab_q),
      .senab_q (senab_q),
      .gate_ok (gate_ok)
   );

   // Translation-register trap for the supervisor
   assign vm_ok = !(vm_trap && (priv == PRV_SUPER) && (csr_addr == SATP_ADDR));

   assign access_ok = defined && field_ok && vm_ok && gate_ok;

   // Assertions
   p_ro_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (is_write && (csr_addr[11:10] == 2'b11)) |-> !access_ok);

   p_priv_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (priv < csr_addr[9:8]) |-> !access_ok);

   p_vm_trap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (vm_trap && (priv == PRV_SUPER) && (csr_addr == SATP_ADDR)) |-> !access_ok);

   p_hpm_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((csr_addr > 12'hC02) && (csr_addr <= 12'hC1F)) |-> !access_ok);

   p_rsvd_priv_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (priv == PRV_RSVD) |-> !access_ok);

   p_gaps_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((csr_addr == 12'h3B0) || (csr_addr == 12'h101)) |-> !access_ok);

endmodule

// File: tb/sim_csr_perm_gate.sv
`timescale 1ns/100ps
module sim_csr_perm_gate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] csr_addr = '0;
   logic [1:0]  priv = 2'b11;
   logic        is_write = 1'b0;
   logic        vm_trap = 1'b0;
   logic        menab_we = 1'b0;
   logic [63:0] menab_wdata = '0;
   logic        senab_we = 1'b0;
   logic [63:0] senab_wdata = '0;
   logic [31:0] menab_q, senab_q;
   logic        access_ok;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   csr_perm_gate u0 (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .priv(priv),
      .is_write(is_write), .vm_trap(vm_trap),
      .menab_we(menab_we), .menab_wdata(menab_wdata),
      .senab_we(senab_we), .senab_wdata(senab_wdata),
      .menab_q(menab_q), .senab_q(senab_q), .access_ok(access_ok)
   );

   // Reference model written from the requirement list
   function automatic bit ref_ok(logic [11:0] a, logic [1:0] p, bit wr, bit tvm,
                                 logic [2:0] me, logic [2:0] se);
      bit m_only, s_up, any, def, ok;
      int ai = int'(a);
      if (p == 2'b10) return 0;                               // R10
      m_only = (ai >= 'hF11 && ai <= 'hF14) || (ai >= 'h300 && ai <= 'h306) ||
               (ai >= 'h340 && ai <= 'h344) || ai == 'h3A0 || ai == 'h7A0;
      s_up   = ai == 'h100 || (ai >= 'h102 && ai <= 'h106) ||
               (ai >= 'h140 && ai <= 'h144) || ai == 'h180;
      any    = (ai >= 'hC00 && ai <= 'hC02);
      def    = (m_only && p == 2'b11) || (s_up && (p == 2'b11 || p == 2'b01)) || any;
      ok     = def;
      if (wr && a[11:10] == 2'b11) ok = 0;                    // R1
      if (p < a[9:8]) ok = 0;                                 // R2
      if (tvm && p == 2'b01 && ai == 'h180) ok = 0;           // R3
      if (any && p == 2'b01 && !me[ai - 'hC00]) ok = 0;       // R4
      if (any && p == 2'b00 && !se[ai - 'hC00]) ok = 0;       // R5
      if (ai >= 'hC03 && ai <= 'hC1F) ok = 0;                 // R6
      return ok;
   endfunction

   function automatic string tag_of(logic [11:0] a, logic [1:0] p, bit wr, bit tvm);
      int ai = int'(a);
      if (p == 2'b10) return "R10";
      if (ai >= 'hC03 && ai <= 'hC1F) return "R6";
      if (ai >= 'hC00 && ai <= 'hC02)
         return (p == 2'b01) ? "R4" : (p == 2'b00) ? "R5" : "R11";
      if (wr && a[11:10] == 2'b11) return "R1";
      if (tvm && ai == 'h180) return "R3";
      if (p < a[9:8]) return "R2";
      if ((ai >= 'hF11 && ai <= 'hF14) || (ai >= 'h300 && ai <= 'h3A0) || ai == 'h7A0) return "R7";
      if ((ai >= 'h100 && ai <= 'h180)) return "R8";
      return "R12";
   endfunction

   task automatic check_bit(string tag, bit act, bit exp, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   task automatic check_word(string tag, logic [31:0] act, logic [31:0] exp, string what);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic write_enables(logic [63:0] mv, logic [63:0] sv);
      @(negedge clk);
      menab_we = 1'b1; menab_wdata = mv;
      senab_we = 1'b1; senab_wdata = sv;
      @(negedge clk);
      menab_we = 1'b0; senab_we = 1'b0;
      #1;
   endtask

   task automatic probe(logic [11:0] a, logic [1:0] p, bit wr, bit tvm);
      logic [2:0] me = menab_q[2:0];
      logic [2:0] se = senab_q[2:0];
      csr_addr = a; priv = p; is_write = wr; vm_trap = tvm;
      #1;
      check_bit(tag_of(a, p, wr, tvm), access_ok, ref_ok(a, p, wr, tvm, me, se),
                $sformatf("addr=%h priv=%b wr=%0b tvm=%0b", a, p, wr, tvm));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R9: reset value of both enable registers
      check_word("R9", menab_q, 32'h0, "machine enable after reset");
      check_word("R9", senab_q, 32'h0, "supervisor enable after reset");
      rst_n = 1'b1;
      @(negedge clk); #1;
      // R4 / R5 with enables cleared
      probe(12'hC00, 2'b01, 1'b0, 1'b0);
      probe(12'hC02, 2'b00, 1'b0, 1'b0);
      // R11: machine mode ungated
      probe(12'hC01, 2'b11, 1'b0, 1'b0);

      // R9: write legalization
      write_enables(64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDE5);
      check_word("R9", menab_q, 32'h7, "machine enable after all-ones write");
      check_word("R9", senab_q, 32'h5, "supervisor enable keeps low bits");
      write_enables(64'hFFFF_FFFF_FFFF_FFF8, 64'h0000_0000_0000_0002);
      check_word("R9", menab_q, 32'h0, "machine enable upper bits dropped");
      check_word("R9", senab_q, 32'h2, "supervisor enable single bit");

      // R3 spot checks
      write_enables(64'h0, 64'h0);
      probe(12'h180, 2'b01, 1'b0, 1'b1);
      probe(12'h180, 2'b01, 1'b1, 1'b0);
      probe(12'h180, 2'b11, 1'b1, 1'b1);
      // R8: hole at 0x3B0
      probe(12'h3B0, 2'b11, 1'b0, 1'b0);

      // Full sweep, R1 R2 R7 R8 R10 R12
      write_enables(64'h5, 64'h3);
      for (int p = 0; p < 4; p++)
         for (int w = 0; w < 2; w++)
            for (int t = 0; t < 2; t++)
               for (int a = 0; a < 4096; a++)
                  probe(12'(a), 2'(p), w[0], t[0]);

      // Counter window under every enable combination, R4 R5 R6 R11
      for (int k = 0; k < 64; k++) begin
         write_enables(64'(k & 7), 64'(k >> 3));
         check_word("R9", menab_q, 32'(k & 7), "machine enable readback");
         check_word("R9", senab_q, 32'(k >> 3), "supervisor enable readback");
         for (int p = 0; p < 4; p++)
            for (int w = 0; w < 2; w++)
               for (int a = 'hBFE; a <= 'hC21; a++)
                  probe(12'(a), 2'(p), w[0], 1'b0);
      end

      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 120000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule